// File: doc/BRIEF.md
# Streaming Lowest-Four Value Sorter

This block watches a stream of unsigned samples, one per clock on which the valid strobe is high. It keeps the four smallest values seen since it was last emptied, and drops everything larger. Storage is a short chain of ordered registers that acts as an insertion network. A new sample drops into the first slot whose entry is larger than itself, and every larger entry moves one slot down the chain. The entry pushed out of the last slot is lost.

An empty slot holds the all-ones code. That code serves both as the "no value" marker and as the clearing mechanism. When the dump control is held high, the smallest stored value is presented on the output. At each clock edge the chain shifts toward the head, and all-ones enters at the tail. The kept values therefore leave in ascending order, one per clock. After as many dump clocks as there are slots, the block is empty again and ready for a new stream with no separate clear step.

Width and slot count are parameters, with defaults of 8 bits and 4 slots.

Top module: `lowest_n_sorter`

## Requirements
- R1: While and after synchronous reset (rst_n low at a clock edge), every slot is empty (all-ones). A dump then shows out_data = all-ones and out_valid = 0.
- R2: After any sequence of accepted samples, the slots hold the DEPTH smallest accepted values since the block was last empty, in ascending order from the head. Larger values are discarded.
- R3: Equal samples each occupy their own slot. For example, five samples of 5 leave four slots at 5.
- R4: While dump is high, out_data equals the head slot in that same cycle. Each clock edge with dump high removes the head and moves every other slot one place toward the head, so successive dump cycles give ascending values.
- R5: out_valid is 1 exactly when dump is high and the head slot is not all-ones. It is 0 in every cycle with dump low.
- R6: After DEPTH consecutive dump cycles, all slots are all-ones. A following stream is sorted from scratch with no extra clear cycle.
- R7: A sample presented with in_valid high while dump is high is not stored.
- R8: A cycle with in_valid low leaves the slots unchanged.
- R9: A dump shorter than DEPTH cycles removes only that many values. The rest stay sorted, and later samples merge with them.
- R10: An all-ones sample is never stored, so it leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W | Sample value, unsigned |
| in_valid | input | 1 | Sample strobe |
| dump | input | 1 | Read-out command; shifts the chain toward the head each clock |
| out_data | output | DATA_W | Head slot (smallest kept value) |
| out_valid | output | 1 | High during dump when out_data holds a real value |

## Verification
Storing a sample and shifting out during a dump compete for the same cycle. Dump takes priority, and the colliding sample is dropped. The bench provokes this by holding in_valid high with fresh data during random and directed dump bursts. Its reference model skips the insert in those cycles, so any stored intruder shows up as a mismatch in a later read-out. Partial dumps that are immediately followed by new samples test the second overlap: refill at the tail against insertion into the remaining entries.

// File: rtl/lsort_pkg.sv
// Package: shared defaults for the lowest-N sorter.
// Assumes: nothing; constants only.
package lsort_pkg;
    localparam int unsigned LSORT_DATA_W_DEF = 8;
    localparam int unsigned LSORT_DEPTH_DEF  = 4;
endpackage

// File: rtl/lsort_stage.sv
// One slot of the insertion chain.
// On an accepted sample it does one of three things. It takes the slot above
// if that slot's entry was displaced. It takes the sample if the sample is
// strictly smaller than its own entry. Otherwise it holds. During dump it
// loads the entry of the slot below.
// Assumes: the chain is kept in ascending order, so at most one slot takes the sample.
module lsort_stage #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] sample,
    input  logic              prev_lt,
    input  logic [DATA_W-1:0] prev_val,
    input  logic [DATA_W-1:0] next_val,
    output logic [DATA_W-1:0] val,
    output logic              lt
);
    localparam logic [DATA_W-1:0] EMPTY = '1;

    // Flag: the sample would displace this slot's entry.
    always_comb lt = (sample < val);

    // Slot register: reset, shift, insert or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        val <= EMPTY;
        else if (shift)    val <= next_val;
        else if (load) begin
            if (prev_lt)   val <= prev_val;
            else if (lt)   val <= sample;
        end
    end

    // R4: a dump edge moves the lower neighbour's entry into this slot.
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (val == $past(next_val)));
    // R8: with neither sample nor dump, the slot keeps its entry.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(val));
endmodule

// File: rtl/lsort_head.sv
// Output stage: presents the head slot and flags it as valid only during
// dump when it holds a real value.
// Assumes: all-ones marks an empty slot.
module lsort_head #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump,
    input  logic [DATA_W-1:0] head,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam logic [DATA_W-1:0] EMPTY = '1;

    // Output drive: head value and its qualifier.
    always_comb begin
        out_data  = head;
        out_valid = dump && (head != EMPTY);
    end

    // R5: valid never appears outside a dump.
    p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> dump);
endmodule

// File: rtl/lowest_n_sorter.sv
// Top: keeps the DEPTH smallest samples of a stream in an ordered register
// chain and reads them out in ascending order on dump.
// Assumes: dump has priority over in_valid; all-ones means empty.
module lowest_n_sorter #(
    parameter int unsigned DATA_W = lsort_pkg::LSORT_DATA_W_DEF,
    parameter int unsigned DEPTH  = lsort_pkg::LSORT_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              dump,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam logic [DATA_W-1:0] EMPTY = '1;
    localparam int unsigned       CW    = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_val [DEPTH];
    logic [DEPTH-1:0]  slot_lt;
    logic              accept;

    // Accept a sample only outside a dump (R7).
    always_comb accept = in_valid && !dump;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              p_lt;
        logic [DATA_W-1:0] p_val;
        logic [DATA_W-1:0] n_val;

        // Neighbour wiring: the head sees no upstream, the tail refills with empty.
        if (g == 0) begin : g_first
            always_comb begin
                p_lt  = 1'b0;
                p_val = EMPTY;
            end
        end else begin : g_mid
            always_comb begin
                p_lt  = slot_lt[g-1];
                p_val = slot_val[g-1];
            end
        end
        if (g == DEPTH - 1) begin : g_last
            always_comb n_val = EMPTY;
        end else begin : g_body
            always_comb n_val = slot_val[g+1];
        end

        lsort_stage #(.DATA_W(DATA_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .shift    (dump),
            .sample   (in_data),
            .prev_lt  (p_lt),
            .prev_val (p_val),
            .next_val (n_val),
            .val      (slot_val[g]),
            .lt       (slot_lt[g])
        );

        if (g > 0) begin : g_chk
            // R2: the chain stays in ascending order.
            p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
                slot_val[g-1] <= slot_val[g]);
            // R2: a displacement upstream implies displacement downstream.
            p_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
                slot_lt[g-1] |-> slot_lt[g]);
        end
    end

    lsort_head #(.DATA_W(DATA_W)) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .dump      (dump),
        .head      (slot_val[0]),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Checker state: consecutive dump edges, saturating at DEPTH.
    logic [CW-1:0] dump_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                          dump_run <= '0;
        else if (!dump)                      dump_run <= '0;
        else if (dump_run != CW'(DEPTH))     dump_run <= dump_run + 1'b1;
    end

    // R6: a full-length dump leaves the head (and so every slot) empty.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_run == CW'(DEPTH)) |-> (slot_val[0] == EMPTY));
endmodule

// File: tb/lowest_n_sorter_bench.sv
module lowest_n_sorter_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  W = 8;
    localparam int  N = 4;
    localparam logic [W-1:0] E = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         dump = 1'b0;
    logic [W-1:0] out_data;
    logic         out_valid;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic [W-1:0] m [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    lowest_n_sorter #(.DATA_W(W), .DEPTH(N)) u_lowest_n_sorter (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .dump(dump), .out_data(out_data), .out_valid(out_valid)
    );

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference insert: sorted, strict compare so ties land after.
    task automatic model_insert(input logic [W-1:0] x);
        for (int i = N - 1; i >= 1; i--) begin
            if (x < m[i-1])   m[i] = m[i-1];
            else if (x < m[i]) m[i] = x;
        end
        if (x < m[0]) m[0] = x;
    endtask

    task automatic model_shift();
        for (int i = 0; i < N - 1; i++) m[i] = m[i+1];
        m[N-1] = E;
    endtask

    // One clock: drive after the falling edge, check, then advance the model.
    task automatic step(input logic [W-1:0] x, input logic v, input logic d, input string tag);
        @(negedge clk);
        in_data = x; in_valid = v; dump = d;
        #1;
        chk(int'(out_valid), int'(d && (m[0] != E)), "R5");
        if (d) chk(int'(out_data), int'(m[0]), tag);
        @(posedge clk);
        if (d) model_shift();
        else if (v) model_insert(x);
    endtask

    task automatic dump_all(input string tag);
        for (int k = 0; k < N + 1; k++) step(8'($urandom), 1'b0, 1'b1, tag);
    endtask

    task automatic put(input logic [W-1:0] x);
        step(x, 1'b1, 1'b0, "R2");
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) m[i] = E;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: empty after reset
        step(8'h00, 1'b0, 1'b1, "R1");
        // R2: basic stream keeps the four smallest
        put(8'd90); put(8'd14); put(8'd60); put(8'd33); put(8'd7); put(8'd200); put(8'd21);
        dump_all("R2");
        // R3: duplicates each hold a slot
        put(8'd5); put(8'd5); put(8'd9); put(8'd5); put(8'd5); put(8'd5);
        dump_all("R3");
        // R7: samples during dump are ignored
        put(8'd40); put(8'd50);
        step(8'd1, 1'b1, 1'b1, "R7");
        step(8'd2, 1'b1, 1'b1, "R7");
        step(8'd3, 1'b1, 1'b1, "R7");
        dump_all("R7");
        // R8: invalid cycles have no effect
        put(8'd30);
        step(8'd0, 1'b0, 1'b0, "R8");
        step(8'd1, 1'b0, 1'b0, "R8");
        dump_all("R8");
        // R9: partial dump then merge
        put(8'd10); put(8'd20); put(8'd30); put(8'd40);
        step(8'd0, 1'b0, 1'b1, "R9");
        step(8'd0, 1'b0, 1'b1, "R9");
        put(8'd25); put(8'd35); put(8'd5);
        dump_all("R9");
        // R10: all-ones sample has no effect
        put(8'd100); put(E); put(E);
        dump_all("R10");
        // R6: full dump then fresh stream, no clear cycle
        put(8'd3); put(8'd4); put(8'd8); put(8'd1); put(8'd2);
        for (int k = 0; k < N; k++) step(8'd0, 1'b0, 1'b1, "R6");
        put(8'd77); put(8'd66);
        dump_all("R6");
        // Random phase with dump collisions (R4 data checks)
        for (int it = 0; it < 3000; it++) begin
            if ($urandom % 10 == 0) begin
                int len = 1 + int'($urandom % 6);
                for (int k = 0; k < len; k++)
                    step(8'($urandom), 1'($urandom), 1'b1, "R4");
            end else begin
                logic [W-1:0] x = ($urandom % 3 == 0) ? 8'($urandom % 16) : 8'($urandom);
                step(x, ($urandom % 4) != 0, 1'b0, "R2");
            end
        end
        dump_all("R4");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule